// File: doc/BRIEF.md
# Multi-Format Masked Identifier Acceptance Filter

This block decides whether a received frame identifier should be kept. It holds no state beyond its output register. It compares the identifier against eight 32-bit filter words that software supplies as static inputs. A single format select decides how every word is read. A word can hold one whole identifier with its IDE and RTR flags, two 16-bit elements that each carry IDE, RTR and a 14-bit identifier prefix, or four 8-bit identifier prefixes. All eight words are read the same way.

Each filter word has a mask word. When per-word masking is enabled, word n takes its own mask n. Otherwise the block uses three shared masks: the last filter word takes legacy mask B, the second-to-last takes legacy mask A, and all the others take the global mask. A strobe qualifies the frame. One clock later the block reports whether the frame is accepted and the index of the lowest-numbered element that matched.

Top module: `afl_accept_filter`

## Requirements
- R1: While rst_n is low, and at the first clock edge after it rises, dec_valid, accept and match_idx are all 0.
- R2: dec_valid is 1 in exactly the cycle after a cycle in which frame_valid was sampled 1. accept is never 1 unless dec_valid is 1.
- R3: The comparison key is 29 bits. For IDE=1 it is frame_id[28:0]. For IDE=0 it is frame_id[10:0] placed in key[28:18], with key[17:0]=0.
- R4: With fmt_sel=0, word n is one element with index n. Its layout is [31]=IDE, [30]=RTR, [29] ignored, [28:0]=key. IDE and RTR both take part in the comparison.
- R5: With fmt_sel=1, the upper half of word n is element 2n and the lower half is element 2n+1. Each half has the layout [15]=IDE, [14]=RTR, [13:0]=key[28:15].
- R6: With fmt_sel=2, byte k of word n, counted from the top (byte 0 = [31:24]), is element 4n+k. It is compared with key[28:21], and IDE and RTR are ignored.
- R7: With fmt_sel=3, every frame is rejected.
- R8: A mask bit of 1 requires the bit at the same position of the element to equal the frame's bit. A mask bit of 0 ignores that bit.
- R9: With indiv_mask_en=1, word n is masked by indiv_masks[32n+31:32n].
- R10: With indiv_mask_en=0, word 6 uses legacy_mask_a, word 7 uses legacy_mask_b, and words 0 to 5 use global_mask. The per-word masks then have no effect.
- R11: When several elements match, match_idx reports the lowest element index.
- R12: A frame that matches no element gives accept=0 and match_idx=0 in its result cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | Strobe qualifying the frame fields |
| frame_id | input | 29 | Received identifier; standard IDs use bits 10:0 |
| frame_ide | input | 1 | Extended-identifier flag of the frame |
| frame_rtr | input | 1 | Remote-request flag of the frame |
| fmt_sel | input | 2 | Table format: 0 whole, 1 halves, 2 bytes, 3 none |
| indiv_mask_en | input | 1 | 1 selects per-word masks, 0 selects legacy masks |
| filt_words | input | 256 | Filter table; word n in bits 32n+31:32n |
| indiv_masks | input | 256 | Per-word masks; mask n in bits 32n+31:32n |
| global_mask | input | 32 | Legacy mask for words 0 to 5 |
| legacy_mask_a | input | 32 | Legacy mask for word 6 |
| legacy_mask_b | input | 32 | Legacy mask for word 7 |
| dec_valid | output | 1 | Result strobe, one cycle after frame_valid |
| accept | output | 1 | Frame matched at least one element |
| match_idx | output | 5 | Lowest matching element index, 0 on reject |

## Verification
The bench builds the block with its default of eight table words. At that size every format exercises its full element range: 8 whole-word elements, 16 halves and 32 bytes. The top byte index of 31 and both legacy-mask words are therefore reachable. A bench-side model extracts elements by shifting instead of slicing and computes the expected result for a vector table that covers all four formats. Directed cases then target RTR sensitivity, IDE indifference in byte mode, partial masks, priority between overlapping matches, and each of the three legacy masks.

// File: rtl/afl_pkg.sv
package afl_pkg;
  localparam int WORD_W = 32;
  localparam int KEY_W  = 29;
  localparam int HALF_W = WORD_W / 2;
  localparam int BYTE_W = WORD_W / 4;

  typedef enum logic [1:0] {
    FMT_WHOLE   = 2'd0,
    FMT_HALF    = 2'd1,
    FMT_QUARTER = 2'd2,
    FMT_NONE    = 2'd3
  } fmt_e;

  // Left-align a standard identifier so every format compares top bits.
  function automatic logic [KEY_W-1:0] make_key(input logic [KEY_W-1:0] id,
                                                input logic ide);
    return ide ? id : {id[10:0], 18'd0};
  endfunction

  // Equality restricted to the bits a mask marks as significant.
  function automatic logic masked_eq(input logic [WORD_W-1:0] rx,
                                     input logic [WORD_W-1:0] ref_w,
                                     input logic [WORD_W-1:0] msk);
    return ((rx ^ ref_w) & msk) == '0;
  endfunction
endpackage

// File: rtl/afl_mask_sel.sv
module afl_mask_sel
  import afl_pkg::*;
#(
  parameter int N_WORDS = 8
) (
  input  logic                      indiv_en,
  input  logic [N_WORDS*WORD_W-1:0] indiv_masks,
  input  logic [WORD_W-1:0]         global_mask,
  input  logic [WORD_W-1:0]         legacy_mask_a,
  input  logic [WORD_W-1:0]         legacy_mask_b,
  output logic [N_WORDS*WORD_W-1:0] sel_masks
);
  localparam int LEG_A_WORD = N_WORDS - 2;
  localparam int LEG_B_WORD = N_WORDS - 1;

  for (genvar n = 0; n < N_WORDS; n++) begin : g_word
    logic [WORD_W-1:0] legacy;
    if (n == LEG_B_WORD) begin : g_b
      assign legacy = legacy_mask_b;
    end else if (n == LEG_A_WORD) begin : g_a
      assign legacy = legacy_mask_a;
    end else begin : g_g
      assign legacy = global_mask;
    end
    assign sel_masks[n*WORD_W +: WORD_W] =
      indiv_en ? indiv_masks[n*WORD_W +: WORD_W] : legacy;
  end
endmodule

// File: rtl/afl_word_match.sv
module afl_word_match
  import afl_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] mask,
  input  logic [KEY_W-1:0]  key,
  input  logic              ide,
  input  logic              rtr,
  output logic              hit_whole,
  output logic [1:0]        hit_half,
  output logic [3:0]        hit_quarter
);
  logic [WORD_W-1:0] whole_rx;
  logic [HALF_W-1:0] half_rx;
  logic [BYTE_W-1:0] byte_rx;

  assign whole_rx  = {ide, rtr, 1'b0, key};
  assign half_rx   = {ide, rtr, key[KEY_W-1 -: HALF_W-2]};
  assign byte_rx   = key[KEY_W-1 -: BYTE_W];
  // Bit 29 carries no meaning in whole-word layout.
  assign hit_whole = masked_eq(whole_rx, word, mask & ~(32'd1 << 29));

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign hit_half[h] = masked_eq(WORD_W'(half_rx),
                                   WORD_W'(word[WORD_W-1-h*HALF_W -: HALF_W]),
                                   WORD_W'(mask[WORD_W-1-h*HALF_W -: HALF_W]));
  end

  for (genvar q = 0; q < 4; q++) begin : g_quarter
    assign hit_quarter[q] = masked_eq(WORD_W'(byte_rx),
                                      WORD_W'(word[WORD_W-1-q*BYTE_W -: BYTE_W]),
                                      WORD_W'(mask[WORD_W-1-q*BYTE_W -: BYTE_W]));
  end
endmodule

// File: rtl/afl_first_hit.sv
module afl_first_hit #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/afl_accept_filter.sv
module afl_accept_filter
  import afl_pkg::*;
#(
  parameter int N_WORDS = 8,
  localparam int N_ELEM = N_WORDS * 4,
  localparam int IDX_W  = $clog2(N_ELEM)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_valid,
  input  logic [KEY_W-1:0]          frame_id,
  input  logic                      frame_ide,
  input  logic                      frame_rtr,
  input  logic [1:0]                fmt_sel,
  input  logic                      indiv_mask_en,
  input  logic [N_WORDS*WORD_W-1:0] filt_words,
  input  logic [N_WORDS*WORD_W-1:0] indiv_masks,
  input  logic [WORD_W-1:0]         global_mask,
  input  logic [WORD_W-1:0]         legacy_mask_a,
  input  logic [WORD_W-1:0]         legacy_mask_b,
  output logic                      dec_valid,
  output logic                      accept,
  output logic [IDX_W-1:0]          match_idx
);
  logic [KEY_W-1:0]          key;
  logic [N_WORDS*WORD_W-1:0] sel_masks;
  logic                      hit_whole   [N_WORDS];
  logic [1:0]                hit_half    [N_WORDS];
  logic [3:0]                hit_quarter [N_WORDS];
  logic [N_ELEM-1:0]         elem_hit;
  logic                      elem_any;
  logic [IDX_W-1:0]          first_idx;

  assign key = make_key(frame_id, frame_ide);

  afl_mask_sel #(.N_WORDS(N_WORDS)) u_mask_sel (
    .indiv_en      (indiv_mask_en),
    .indiv_masks   (indiv_masks),
    .global_mask   (global_mask),
    .legacy_mask_a (legacy_mask_a),
    .legacy_mask_b (legacy_mask_b),
    .sel_masks     (sel_masks)
  );

  for (genvar n = 0; n < N_WORDS; n++) begin : g_word
    afl_word_match u_match (
      .word        (filt_words[n*WORD_W +: WORD_W]),
      .mask        (sel_masks[n*WORD_W +: WORD_W]),
      .key         (key),
      .ide         (frame_ide),
      .rtr         (frame_rtr),
      .hit_whole   (hit_whole[n]),
      .hit_half    (hit_half[n]),
      .hit_quarter (hit_quarter[n])
    );
  end

  // Number elements by format: word-major, most significant part first.
  always_comb begin
    elem_hit = '0;
    case (fmt_e'(fmt_sel))
      FMT_WHOLE: begin
        for (int n = 0; n < N_WORDS; n++) elem_hit[n] = hit_whole[n];
      end
      FMT_HALF: begin
        for (int n = 0; n < N_WORDS; n++)
          for (int h = 0; h < 2; h++) elem_hit[2*n+h] = hit_half[n][h];
      end
      FMT_QUARTER: begin
        for (int n = 0; n < N_WORDS; n++)
          for (int q = 0; q < 4; q++) elem_hit[4*n+q] = hit_quarter[n][q];
      end
      default: elem_hit = '0;
    endcase
  end

  afl_first_hit #(.N(N_ELEM), .IDX_W(IDX_W)) u_first (
    .vec   (elem_hit),
    .found (elem_any),
    .idx   (first_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      accept    <= 1'b0;
      match_idx <= '0;
    end else begin
      dec_valid <= frame_valid;
      accept    <= frame_valid & elem_any;
      match_idx <= (frame_valid & elem_any) ? first_idx : '0;
    end
  end
endmodule

// File: rtl/afl_accept_filter_chk.sv
module afl_accept_filter_chk #(
  parameter int N_WORDS = 8,
  parameter int IDX_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_valid,
  input logic [1:0]       fmt_sel,
  input logic             elem_any,
  input logic             dec_valid,
  input logic             accept,
  input logic [IDX_W-1:0] match_idx
);
  AST_STROBE_YIELDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> dec_valid); // R2
  AST_RESULT_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(frame_valid)); // R2
  AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> dec_valid); // R2
  AST_ACCEPT_FOLLOWS_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> (accept == $past(elem_any))); // R12
  AST_REJECT_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> (match_idx == '0)); // R12
  AST_NONE_FMT_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && fmt_sel == 2'd3) |=> !accept); // R7
  AST_WHOLE_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && fmt_sel == 2'd0) |=> (32'(match_idx) < N_WORDS)); // R4
  AST_HALF_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && fmt_sel == 2'd1) |=> (32'(match_idx) < 2 * N_WORDS)); // R5
endmodule

bind afl_accept_filter afl_accept_filter_chk #(.N_WORDS(N_WORDS), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_valid (frame_valid),
  .fmt_sel     (fmt_sel),
  .elem_any    (elem_any),
  .dec_valid   (dec_valid),
  .accept      (accept),
  .match_idx   (match_idx)
);

// File: tb/tb_afl_accept_filter.sv
`timescale 1ns/1ps
module tb_afl_accept_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_valid = 1'b0;
  logic [28:0] frame_id = '0;
  logic        frame_ide = 1'b0;
  logic        frame_rtr = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic        indiv_mask_en = 1'b1;
  logic [31:0] tw [8];
  logic [31:0] tm [8];
  logic [255:0] filt_words, indiv_masks;
  logic [31:0] global_mask = '1, legacy_mask_a = '1, legacy_mask_b = '1;
  logic        dec_valid, accept;
  logic [4:0]  match_idx;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int n = 0; n < 8; n++) begin
      filt_words[n*32 +: 32]  = tw[n];
      indiv_masks[n*32 +: 32] = tm[n];
    end
  end

  afl_accept_filter dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_id(frame_id),
    .frame_ide(frame_ide), .frame_rtr(frame_rtr), .fmt_sel(fmt_sel),
    .indiv_mask_en(indiv_mask_en), .filt_words(filt_words), .indiv_masks(indiv_masks),
    .global_mask(global_mask), .legacy_mask_a(legacy_mask_a), .legacy_mask_b(legacy_mask_b),
    .dec_valid(dec_valid), .accept(accept), .match_idx(match_idx)
  );

  typedef struct packed {
    logic [1:0]  fmt;
    logic        ind;
    logic [28:0] id;
    logic        ide;
    logic        rtr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 29'h01ABCDE0, 1'b1, 1'b0},
    '{2'd0, 1'b1, 29'h01ABCDE1, 1'b1, 1'b0},
    '{2'd0, 1'b1, 29'h00000123, 1'b0, 1'b0},
    '{2'd1, 1'b1, 29'h000002A5, 1'b0, 1'b0},
    '{2'd1, 1'b1, 29'h00000123, 1'b0, 1'b0},
    '{2'd1, 1'b1, 29'h1DC00000, 1'b1, 1'b1},
    '{2'd2, 1'b1, 29'h0F0F0F0F, 1'b1, 1'b0},
    '{2'd2, 1'b1, 29'h00000123, 1'b0, 1'b1},
    '{2'd2, 1'b1, 29'h1FFFFFFF, 1'b1, 1'b0},
    '{2'd3, 1'b1, 29'h01ABCDE0, 1'b1, 1'b0}
  };

  function automatic logic [31:0] mask_of(input int n, input logic ind);
    if (ind) return tm[n];
    if (n == 7) return legacy_mask_b;
    if (n == 6) return legacy_mask_a;
    return global_mask;
  endfunction

  // Shift-based model of the requirements (R3 to R12).
  task automatic ref_eval(input logic [1:0] f, input logic ind, input logic [28:0] id,
                          input logic ide, input logic rtr,
                          output logic acc, output int idx);
    int per, wd, sh;
    longint unsigned key, rx, fw, fm, lim;
    acc = 1'b0;
    idx = 0;
    per = (f == 2'd0) ? 1 : (f == 2'd1) ? 2 : (f == 2'd2) ? 4 : 0;
    key = ide ? longint'(id) : (longint'(id & 29'h7FF) << 18);
    for (int e = 0; e < 8 * per; e++) begin
      wd  = 32 / per;
      sh  = 32 - wd * (e % per + 1);
      lim = (longint'(1) << wd) - 1;
      fw  = (longint'(tw[e / per]) >> sh) & lim;
      fm  = (longint'(mask_of(e / per, ind)) >> sh) & lim;
      if (per == 1) begin
        rx = (longint'(ide) << 31) | (longint'(rtr) << 30) | key;
        fm = fm & ~(longint'(1) << 29);
      end else if (per == 2) begin
        rx = (longint'(ide) << 15) | (longint'(rtr) << 14) | (key >> 15);
      end else begin
        rx = (key >> 21) & 8'hFF;
      end
      if (!acc && ((fw ^ rx) & fm) == 0) begin
        acc = 1'b1;
        idx = e;
      end
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] f, input logic ind, input logic [28:0] id,
                      input logic ide, input logic rtr);
    @(negedge clk);
    fmt_sel = f; indiv_mask_en = ind; frame_id = id; frame_ide = ide; frame_rtr = rtr;
    frame_valid = 1'b1;
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic acc, input int idx);
    chk(req, "dec_valid", int'(dec_valid), 1);
    chk(req, "accept", int'(accept), int'(acc));
    chk(req, "match_idx", int'(match_idx), acc ? idx : 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    logic racc;
    int ridx;
    tw[0] = 32'h81ABCDE0; tw[1] = 32'h048C0000; tw[2] = 32'h1528C777;
    tw[3] = 32'h5A5A5A5A; tw[4] = 32'h3C3C3C3C; tw[5] = 32'h11227833;
    tw[6] = 32'h66666666; tw[7] = 32'h77777777;
    for (int n = 0; n < 8; n++) tm[n] = '1;

    // R1: reset values, during reset and after the first edge out of it
    repeat (3) @(negedge clk);
    chk("R1", "reset dec_valid", int'(dec_valid), 0);
    chk("R1", "reset accept", int'(accept), 0);
    chk("R1", "reset match_idx", int'(match_idx), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "post-reset accept", int'(accept), 0);

    // Vector table against the bench model
    for (int v = 0; v < NV; v++) begin
      ref_eval(VECS[v].fmt, VECS[v].ind, VECS[v].id, VECS[v].ide, VECS[v].rtr, racc, ridx);
      send(VECS[v].fmt, VECS[v].ind, VECS[v].id, VECS[v].ide, VECS[v].rtr);
      expect_res("R3-vector", racc, ridx);
    end

    // R2: no strobe, no result
    @(negedge clk);
    chk("R2", "idle dec_valid", int'(dec_valid), 0);
    chk("R2", "idle accept", int'(accept), 0);

    // R4, R3: whole-word extended and standard, RTR participates
    send(2'd0, 1'b1, 29'h01ABCDE0, 1'b1, 1'b0); expect_res("R4", 1'b1, 0);
    send(2'd0, 1'b1, 29'h00000123, 1'b0, 1'b0); expect_res("R3", 1'b1, 1);
    send(2'd0, 1'b1, 29'h00000123, 1'b0, 1'b1); expect_res("R4", 1'b0, 0);
    // R5: upper half of word 2
    send(2'd1, 1'b1, 29'h000002A5, 1'b0, 1'b0); expect_res("R5", 1'b1, 4);
    // R6: byte 2 of word 5, IDE ignored
    send(2'd2, 1'b1, 29'h0F0F0F0F, 1'b1, 1'b0); expect_res("R6", 1'b1, 22);
    send(2'd2, 1'b1, 29'h000003C0, 1'b0, 1'b1); expect_res("R6", 1'b1, 22);
    // R7: reserved format rejects a frame that would match
    send(2'd3, 1'b1, 29'h01ABCDE0, 1'b1, 1'b0); expect_res("R7", 1'b0, 0);
    // R8: partial mask ignores the identifier LSB on word 1
    send(2'd0, 1'b1, 29'h00000122, 1'b0, 1'b0); expect_res("R8", 1'b0, 0);
    tm[1] = ~32'h0004_0000;
    send(2'd0, 1'b1, 29'h00000122, 1'b0, 1'b0); expect_res("R8", 1'b1, 1);
    tm[1] = '1;
    // R9, R11: open mask on word 3, lower match wins
    tm[3] = '0;
    send(2'd0, 1'b1, 29'h00000123, 1'b0, 1'b0); expect_res("R11", 1'b1, 1);
    send(2'd0, 1'b1, 29'h00000555, 1'b0, 1'b0); expect_res("R9", 1'b1, 3);
    // R10: legacy mode ignores per-word masks
    send(2'd0, 1'b0, 29'h00000555, 1'b0, 1'b0); expect_res("R10", 1'b0, 0);
    tm[3] = '1;
    legacy_mask_a = '0;
    send(2'd0, 1'b0, 29'h00000555, 1'b0, 1'b0); expect_res("R10", 1'b1, 6);
    legacy_mask_a = '1; legacy_mask_b = '0;
    send(2'd0, 1'b0, 29'h00000555, 1'b0, 1'b0); expect_res("R10", 1'b1, 7);
    legacy_mask_b = '1; global_mask = '0;
    send(2'd2, 1'b0, 29'h00000555, 1'b0, 1'b0); expect_res("R10", 1'b1, 0);
    global_mask = '1;
    // R12: no match anywhere
    send(2'd1, 1'b1, 29'h1FFFFFFF, 1'b1, 1'b1); expect_res("R12", 1'b0, 0);

    finish_run();
  end
endmodule